// File: doc/BRIEF.md
# Out-of-Order Section Reassembly Tracker

This block rebuilds a large binary image from fixed-size payload sections. The sections are broadcast in a repeating cycle and can arrive in any order. Each section begins with a header pulse. The header carries the section's index, the index of the final section, a group index and a pass/fail flag from the upstream CRC check. The payload bytes follow, and an end pulse closes the section. The block uses the section index and the group index to work out where each payload byte belongs in a reassembly memory. It then drives a plain write port into that memory.

A bitmap records which sections have already been stored. When a section is repeated in a later cycle, the block skips it. It also drops a section that failed its CRC and waits for a clean copy to come round again. It refuses any section whose header disagrees with the image description latched from the first accepted section.

The block counts the distinct sections stored and keeps a running total of payload bytes. It raises `done` once every section from zero up to the announced final index is present and the byte total equals the announced image size exactly. A synchronous reset discards all of this state so that reassembly starts again from nothing.

Top module: `sect_reasm`

## Requirements
- R1: The payload byte at offset k of section s in group g is written to address (g × SEC_PER_GRP + s) × SEC_BYTES + k, with `mem_we` high in the cycle after the byte is presented. Sections may arrive in any order.
- R2: `done` rises only after every section from 0 to the latched final index has been stored and the byte total equals `core_size`. `done` stays low while any section is missing.
- R3: A header for a section that is already stored produces no memory writes and leaves `progress` unchanged.
- R4: A header with `hdr_crc_ok` low is ignored, and its bytes cause no writes. A later clean copy of the same section is accepted normally.
- R5: `progress` equals the number of distinct sections stored since reset. It rises by at most one per cycle.
- R6: A clean header whose final index differs from the value latched at the first accepted section sets the sticky `clash` output. That section is ignored.
- R7: The last section may be shorter than SEC_BYTES. If the byte total differs from `core_size`, `done` stays low, and it rises once `core_size` matches the total.
- R8: The group index latched at the first accepted section offsets every address. A later clean header carrying a different group index sets `clash` and is ignored.
- R9: Reset clears `done`, `progress`, `clash`, the bitmap and the byte total. A section stored before the reset is written again when it arrives after the reset.
- R10: Bytes presented beyond SEC_BYTES within one section are dropped without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header pulse opening a section |
| hdr_sec | input | SEC_W | Section index within its group |
| hdr_last | input | SEC_W | Index of the final section of the image |
| hdr_grp | input | GRP_W | Group index of the section |
| hdr_crc_ok | input | 1 | Upstream CRC verdict for this section (1 = clean) |
| byte_valid | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| sec_end | input | 1 | Pulse closing the current section |
| core_size | input | SIZE_W | Announced image size in bytes |
| mem_we | output | 1 | Reassembly memory write enable |
| mem_addr | output | ADDR_W | Reassembly memory byte address |
| mem_wdata | output | 8 | Reassembly memory write data |
| progress | output | CNT_W | Count of distinct sections stored |
| done | output | 1 | Image complete |
| clash | output | 1 | Sticky: header inconsistent with the latched description |

## Verification
The hardest state to reach is a complete bitmap whose byte total still disagrees with the announced size. Every section is present, yet completion must be held back. The bench reaches this state by sending every section, including a short final one, while `core_size` is set one byte too large. It confirms that `done` stays low, then corrects `core_size` and watches `done` rise a cycle later. Repeated and corrupted copies are sent after sections are already stored, or before their clean copies. This shows that only the bitmap, not arrival order, decides whether memory is touched.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [1:0] {
    HDR_IGNORE = 2'd0,
    HDR_ACCEPT = 2'd1,
    HDR_CLASH  = 2'd2
  } hdr_verdict_e;
endpackage

// File: rtl/sect_gate.sv
// Header admission: decides whether a section is taken, skipped or flagged.
module sect_gate #(
  parameter int SEC_W = 8,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_valid,
  input  logic [SEC_W-1:0] hdr_sec,
  input  logic [SEC_W-1:0] hdr_last,
  input  logic [GRP_W-1:0] hdr_grp,
  input  logic             hdr_crc_ok,
  input  logic             seen_hit,
  output logic             accept,
  output logic [SEC_W-1:0] last_q,
  output logic [GRP_W-1:0] grp_q,
  output logic             locked_q,
  output logic             clash_q
);
  import rsm_pkg::*;

  hdr_verdict_e verdict;

  always_comb begin
    verdict = HDR_IGNORE;
    if (hdr_valid && hdr_crc_ok && (hdr_sec <= hdr_last)) begin
      if (locked_q && ((hdr_last != last_q) || (hdr_grp != grp_q)))
        verdict = HDR_CLASH;
      else if (locked_q && seen_hit)
        verdict = HDR_IGNORE;
      else
        verdict = HDR_ACCEPT;
    end
  end

  assign accept = (verdict == HDR_ACCEPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      grp_q    <= '0;
      locked_q <= 1'b0;
      clash_q  <= 1'b0;
    end else begin
      if (verdict == HDR_ACCEPT && !locked_q) begin
        last_q   <= hdr_last;
        grp_q    <= hdr_grp;
        locked_q <= 1'b1;
      end
      if (verdict == HDR_CLASH)
        clash_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sect_map.sv
// Received-section bitmap with coverage test and distinct-section counter.
module sect_map #(
  parameter int SEC_PER_GRP = 256,
  parameter int SEC_W       = 8,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [SEC_W-1:0] set_idx,
  input  logic [SEC_W-1:0] query_idx,
  input  logic [SEC_W-1:0] last_q,
  input  logic             locked,
  output logic             query_hit,
  output logic             complete,
  output logic [CNT_W-1:0] count
);
  logic [SEC_PER_GRP-1:0] seen_q;
  logic [SEC_PER_GRP-1:0] covered;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      count  <= '0;
    end else if (set_en && !seen_q[set_idx]) begin
      seen_q[set_idx] <= 1'b1;
      count           <= count + CNT_W'(1);
    end
  end

  assign query_hit = seen_q[query_idx];

  generate
    for (genvar g = 0; g < SEC_PER_GRP; g++) begin : g_cov
      localparam logic [SEC_W-1:0] IDX = SEC_W'(g);
      assign covered[g] = seen_q[g] | (IDX > last_q);
    end
  endgenerate

  assign complete = locked & (&covered);
endmodule

// File: rtl/sect_writer.sv
// Payload placement: turns accepted section bytes into memory writes.
module sect_writer #(
  parameter int SEC_BYTES = 4080,
  parameter int SEC_W     = 8,
  parameter int GRP_W     = 4,
  parameter int ADDR_W    = 24,
  parameter int OFF_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [SEC_W-1:0]  hdr_sec,
  input  logic [GRP_W-1:0]  hdr_grp,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              sec_end,
  output logic              commit,
  output logic [SEC_W-1:0]  commit_idx,
  output logic [OFF_W-1:0]  commit_len,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int IDX_W = GRP_W + SEC_W;

  logic              active_q;
  logic [SEC_W-1:0]  sec_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] base_next;
  logic [IDX_W-1:0]  flat_idx;

  assign flat_idx  = {hdr_grp, hdr_sec};
  assign base_next = ADDR_W'(flat_idx) * ADDR_W'(SEC_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      sec_q     <= '0;
      base_q    <= '0;
      off_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        sec_q    <= hdr_sec;
        base_q   <= base_next;
        off_q    <= '0;
      end else if (active_q && sec_end) begin
        active_q <= 1'b0;
      end else if (active_q && byte_valid && (off_q < OFF_W'(SEC_BYTES))) begin
        mem_we    <= 1'b1;
        mem_addr  <= base_q + ADDR_W'(off_q);
        mem_wdata <= byte_data;
        off_q     <= off_q + OFF_W'(1);
      end
    end
  end

  assign commit     = active_q & sec_end & ~accept;
  assign commit_idx = sec_q;
  assign commit_len = off_q;
endmodule

// File: rtl/sect_reasm.sv
module sect_reasm #(
  parameter int SEC_BYTES   = 4080,
  parameter int SEC_PER_GRP = 256,
  parameter int GRP_W       = 4,
  parameter int SIZE_W      = 32,
  localparam int SEC_W      = $clog2(SEC_PER_GRP),
  localparam int CNT_W      = $clog2(SEC_PER_GRP + 1),
  localparam int OFF_W      = $clog2(SEC_BYTES + 1),
  localparam int ADDR_W     = $clog2(SEC_BYTES * SEC_PER_GRP * (2 ** GRP_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [SEC_W-1:0]  hdr_sec,
  input  logic [SEC_W-1:0]  hdr_last,
  input  logic [GRP_W-1:0]  hdr_grp,
  input  logic              hdr_crc_ok,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              sec_end,
  input  logic [SIZE_W-1:0] core_size,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [CNT_W-1:0]  progress,
  output logic              done,
  output logic              clash
);
  logic              accept;
  logic              seen_hit;
  logic              complete;
  logic              locked_q;
  logic [SEC_W-1:0]  last_q;
  logic [GRP_W-1:0]  grp_q;
  logic              commit;
  logic [SEC_W-1:0]  commit_idx;
  logic [OFF_W-1:0]  commit_len;
  logic [SIZE_W-1:0] total_q;

  sect_gate #(.SEC_W(SEC_W), .GRP_W(GRP_W)) u_gate (
    .clk(clk), .rst(rst),
    .hdr_valid(hdr_valid), .hdr_sec(hdr_sec), .hdr_last(hdr_last),
    .hdr_grp(hdr_grp), .hdr_crc_ok(hdr_crc_ok), .seen_hit(seen_hit),
    .accept(accept), .last_q(last_q), .grp_q(grp_q),
    .locked_q(locked_q), .clash_q(clash)
  );

  sect_map #(.SEC_PER_GRP(SEC_PER_GRP), .SEC_W(SEC_W), .CNT_W(CNT_W)) u_map (
    .clk(clk), .rst(rst),
    .set_en(commit), .set_idx(commit_idx), .query_idx(hdr_sec),
    .last_q(last_q), .locked(locked_q),
    .query_hit(seen_hit), .complete(complete), .count(progress)
  );

  sect_writer #(
    .SEC_BYTES(SEC_BYTES), .SEC_W(SEC_W), .GRP_W(GRP_W),
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_wr (
    .clk(clk), .rst(rst),
    .accept(accept), .hdr_sec(hdr_sec), .hdr_grp(hdr_grp),
    .byte_valid(byte_valid), .byte_data(byte_data), .sec_end(sec_end),
    .commit(commit), .commit_idx(commit_idx), .commit_len(commit_len),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      done    <= 1'b0;
    end else begin
      if (commit)
        total_q <= total_q + SIZE_W'(commit_len);
      done <= complete && (total_q == core_size);
    end
  end
endmodule

// File: rtl/sect_reasm_chk.sv
module sect_reasm_chk #(
  parameter int SIZE_W = 32,
  parameter int SEC_W  = 8,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              mem_we,
  input logic              clash,
  input logic [CNT_W-1:0]  progress,
  input logic [SEC_W-1:0]  last_q,
  input logic [SIZE_W-1:0] total_q,
  input logic [SIZE_W-1:0] core_size
);
  // R2: completion needs the exact byte total
  a_r2_done_size: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(total_q) == $past(core_size)));

  // R2: completion needs every section up to the final index
  a_r2_done_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (progress == CNT_W'(last_q) + CNT_W'(1)));

  // R5: progress never falls and climbs by at most one
  a_r5_progress_step: assert property (@(posedge clk) disable iff (rst)
    (progress == $past(progress)) || (progress == $past(progress) + CNT_W'(1)));

  // R6: clash is sticky
  a_r6_clash_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(clash) |-> clash);

  // R9: reset leaves a clean state
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && progress == '0 && !mem_we && !clash));
endmodule

bind sect_reasm sect_reasm_chk #(.SIZE_W(SIZE_W), .SEC_W(SEC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .mem_we(mem_we), .clash(clash),
  .progress(progress), .last_q(last_q), .total_q(total_q), .core_size(core_size)
);

// File: tb/test_sect_reasm.sv
module test_sect_reasm;
  localparam int SB  = 8;
  localparam int SPG = 16;
  localparam int GW  = 2;
  localparam int SW  = 4;
  localparam int CW  = 5;
  localparam int AW  = 9;
  localparam int MEMN = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0, hdr_crc_ok = 1'b0, byte_valid = 1'b0, sec_end = 1'b0;
  logic [SW-1:0] hdr_sec = '0, hdr_last = '0;
  logic [GW-1:0] hdr_grp = '0;
  logic [7:0] byte_data = '0;
  logic [31:0] core_size = '0;
  logic mem_we, done, clash;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [CW-1:0] progress;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [7:0] model [MEMN];

  always #2 clk = ~clk;

  sect_reasm #(.SEC_BYTES(SB), .SEC_PER_GRP(SPG), .GRP_W(GW)) i_sect_reasm (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_sec(hdr_sec),
    .hdr_last(hdr_last), .hdr_grp(hdr_grp), .hdr_crc_ok(hdr_crc_ok),
    .byte_valid(byte_valid), .byte_data(byte_data), .sec_end(sec_end),
    .core_size(core_size), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .progress(progress), .done(done), .clash(clash)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      model[mem_addr] = mem_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 16) + i);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < MEMN; a++) model[a] = 8'hEE;
    wr_cnt = 0;
  endtask

  task automatic send_sec(int grp, int sec, int last, bit ok, int len, int seed);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_sec = SW'(sec); hdr_last = SW'(last);
    hdr_grp = GW'(grp); hdr_crc_ok = ok;
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      byte_valid = 1'b1; byte_data = pat(seed, i);
      @(negedge clk);
    end
    byte_valid = 1'b0; sec_end = 1'b1;
    @(negedge clk);
    sec_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int region_bad(int base, int len, int seed);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (model[base + i] != pat(seed, i)) bad++;
    return bad;
  endfunction

  task automatic t_reset_state();
    do_reset();
    chk("R9", "done after reset", int'(done), 0);
    chk("R9", "progress after reset", int'(progress), 0);
    chk("R9", "clash after reset", int'(clash), 0);
    chk("R9", "mem_we after reset", int'(mem_we), 0);
  endtask

  task automatic t_out_of_order();
    do_reset();
    core_size = 29;
    send_sec(0, 2, 3, 1, SB, 3);
    send_sec(0, 0, 3, 1, SB, 1);
    send_sec(0, 3, 3, 1, 5, 4);
    chk("R2", "done with section 1 missing", int'(done), 0);
    send_sec(0, 1, 3, 1, SB, 2);
    chk("R2", "done when complete", int'(done), 1);
    chk("R5", "progress four sections", int'(progress), 4);
    chk("R1", "write count", wr_cnt, 29);
    for (int s = 0; s < 4; s++)
      chk("R1", "section bytes placed", region_bad(s * SB, (s == 3) ? 5 : SB, s + 1), 0);
    chk("R7", "short final section bytes", region_bad(3 * SB, 5, 4), 0);
  endtask

  task automatic t_duplicate();
    int w0 = wr_cnt;
    send_sec(0, 2, 3, 1, SB, 9);
    chk("R3", "writes on duplicate", wr_cnt - w0, 0);
    chk("R3", "progress on duplicate", int'(progress), 4);
    chk("R3", "stored data kept", region_bad(2 * SB, SB, 3), 0);
    chk("R3", "done kept", int'(done), 1);
  endtask

  task automatic t_crc_fail();
    do_reset();
    core_size = 16;
    send_sec(0, 0, 1, 0, SB, 5);
    chk("R4", "writes on bad CRC", wr_cnt, 0);
    chk("R4", "progress on bad CRC", int'(progress), 0);
    send_sec(0, 0, 1, 1, SB, 5);
    chk("R4", "writes on clean repeat", wr_cnt, SB);
    send_sec(0, 1, 1, 1, SB, 6);
    chk("R4", "done after clean copies", int'(done), 1);
  endtask

  task automatic t_last_clash();
    do_reset();
    core_size = 32;
    send_sec(0, 0, 3, 1, SB, 1);
    send_sec(0, 1, 5, 1, SB, 2);
    chk("R6", "clash on final index change", int'(clash), 1);
    chk("R6", "writes on clashing section", wr_cnt, SB);
    chk("R6", "progress on clashing section", int'(progress), 1);
  endtask

  task automatic t_size_mismatch();
    do_reset();
    core_size = 30;
    send_sec(0, 0, 3, 1, SB, 1);
    send_sec(0, 1, 3, 1, SB, 2);
    send_sec(0, 2, 3, 1, SB, 3);
    send_sec(0, 3, 3, 1, 5, 4);
    chk("R7", "progress all present", int'(progress), 4);
    chk("R7", "done with wrong size", int'(done), 0);
    @(negedge clk); core_size = 29;
    repeat (2) @(negedge clk);
    chk("R7", "done with matching size", int'(done), 1);
  endtask

  task automatic t_group();
    do_reset();
    core_size = 16;
    send_sec(2, 1, 1, 1, SB, 7);
    chk("R8", "group offset placement", region_bad((2 * SPG + 1) * SB, SB, 7), 0);
    send_sec(1, 0, 1, 1, SB, 8);
    chk("R8", "clash on group change", int'(clash), 1);
    chk("R8", "writes on other group", wr_cnt, SB);
  endtask

  task automatic t_overlong();
    do_reset();
    core_size = SB;
    send_sec(0, 0, 0, 1, SB + 3, 2);
    chk("R10", "writes capped", wr_cnt, SB);
    chk("R10", "done with capped total", int'(done), 1);
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk("R9", "done cleared", int'(done), 0);
    chk("R9", "progress cleared", int'(progress), 0);
    core_size = SB;
    send_sec(0, 0, 0, 1, SB, 5);
    chk("R9", "section rewritten after reset", wr_cnt, SB);
    chk("R9", "rewritten data", region_bad(0, SB, 5), 0);
  endtask

  initial begin
    t_reset_state();
    t_out_of_order();
    t_duplicate();
    t_crc_fail();
    t_last_clash();
    t_size_mismatch();
    t_group();
    t_overlong();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule